// File: doc/BRIEF.md
# Distributed Shared-Bus Arbiter Node

Each processing node on a shared external bus holds one copy of this block. Every copy sees all node request lines, the host request line and the bus-wide lock and busy lines. From these it computes the same bus owner as every other copy, so the system needs no central arbiter. Up to six nodes (IDs 1 to 6) and one host (owner code 0) take part. A run-time input selects the priority mode. In fixed mode the lowest-numbered requester wins. In rotating mode the search starts at the node after the one that owned the bus most recently.

The block also classifies the node's outgoing access from its address. The address map has four parts. Everything below the 1 MiB mark is the node's own internal space. Everything from 8 MiB upward is external memory. In between lies the multiprocessor window, where address bits 22:20 name the target node, and the value 7 in that field means a write to all nodes at once. The node drives its own request line only when the access needs the bus. A read aimed at the all-nodes code is flagged as an error and requests nothing.

Every change of owner passes through one turnaround cycle in which no one owns the bus. A locked owner keeps the bus, and the host is served at the next transfer boundary, ahead of every node.

Top module: `mp_bus_arbiter`

## Requirements
- R1: An access below address 0x100000, or an access in the window 0x100000..0x7FFFFF whose bits 22:20 equal `my_id`, is reported as kind 0 (local) and does not assert `bus_req_out`.
- R2: An access at address 0x800000 or above is reported as kind 3 (external) and asserts `bus_req_out` while `acc_valid` is high.
- R3: An access in the window whose bits 22:20 hold a node ID 1..6 other than `my_id` is reported as kind 1 (remote) and asserts `bus_req_out`.
- R4: An access in the window with bits 22:20 equal to 7 is reported as kind 2 (broadcast). A write asserts `bus_req_out`. A read asserts `bcast_err` and leaves `bus_req_out` low.
- R5: After reset, `owner_id` is 1, `owner_valid` is 1 and `host_grant` is 0.
- R6: With `rotate_en` low, the next owner after a release is the lowest-numbered node whose line in `req_lines` is set. Bit i of `req_lines` belongs to node i+1.
- R7: With `rotate_en` high, the next owner is the first requesting node found when searching upward, wrapping around, from the node after the last node that owned the bus.
- R8: Every change of owner takes exactly one turnaround cycle with `owner_valid` low, after which the new owner is valid. `owner_id` never changes while `owner_valid` stays high.
- R9: While `lock_line` is high, a valid owner keeps the bus, even if it stops requesting, other nodes request, or the host requests.
- R10: When `host_req` is high, `lock_line` is low and `xfer_busy` is low, a node owner gives up the bus to the host (owner 0, `host_grant` high), ahead of any requesting node. The host keeps the bus while `host_req` stays high.
- R11: The owner keeps the bus while its own request stays high, and it stays parked as owner when it releases and nobody else requests.
- R12: `is_master` is high exactly when `owner_valid` is high and `owner_id` equals `my_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | 3 | This node's ID, 1..6 |
| rotate_en | input | 1 | 1 = rotating priority, 0 = fixed priority |
| req_lines | input | 6 | All node request lines as seen on the bus; bit i is node i+1 |
| host_req | input | 1 | Host request line |
| lock_line | input | 1 | Bus lock held by the current owner |
| xfer_busy | input | 1 | Owner's transfer still in progress |
| acc_valid | input | 1 | Outgoing access pending |
| acc_write | input | 1 | Outgoing access is a write |
| acc_addr | input | 32 | Outgoing access address |
| acc_kind | output | 2 | 0 local, 1 remote, 2 broadcast, 3 external |
| bus_req_out | output | 1 | This node's request line |
| bcast_err | output | 1 | Illegal broadcast read |
| owner_id | output | 3 | Current owner: 0 host, 1..6 node |
| owner_valid | output | 1 | Low during a turnaround cycle |
| host_grant | output | 1 | Host owns the bus |
| is_master | output | 1 | This node owns the bus |

## Verification
The assertions assume that `req_lines`, `host_req`, `lock_line` and `xfer_busy` are synchronous and identical at every node. They also assume that `lock_line` is raised only by the current owner, and that `my_id` stays fixed while the bus is in use. The bench drives every input on the falling edge and keeps `my_id` constant during arbitration. It removes the owner's own bit from each request pattern when a handover is wanted, and it raises lock only while a node owns the bus. This keeps the stimulus inside those assumptions.

// File: rtl/mp_arb_pkg.sv
package mp_arb_pkg;

    typedef enum logic [1:0] {
        ACC_LOCAL  = 2'd0,
        ACC_REMOTE = 2'd1,
        ACC_BCAST  = 2'd2,
        ACC_EXTERN = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      need_bus;
        logic      err;
    } decode_t;

    // Owner code reserved for the host
    localparam int HOST_CODE = 0;

    // Candidate visited at step k of a wrapping search that starts after 'last'
    function automatic int rr_candidate(input int last, input int k, input int n);
        return ((last + k) % n) + 1;
    endfunction

endpackage

// File: rtl/mp_addr_decode.sv
module mp_addr_decode
    import mp_arb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 3,
    parameter int SLICE_LSB = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [ID_W-1:0]   my_id,
    output decode_t           dec
);
    localparam int FIELD_MSB = SLICE_LSB + ID_W - 1;
    localparam logic [ID_W-1:0] ALL_ID = {ID_W{1'b1}};

    logic            upper_clear;
    logic [ID_W-1:0] target;

    assign upper_clear = ~|addr[ADDR_W-1:FIELD_MSB+1];
    assign target      = addr[FIELD_MSB:SLICE_LSB];

    always_comb begin
        dec = '{kind: ACC_LOCAL, need_bus: 1'b0, err: 1'b0};
        if (!upper_clear) begin
            dec.kind     = ACC_EXTERN;
            dec.need_bus = 1'b1;
        end else if (target == '0 || target == my_id) begin
            dec.kind = ACC_LOCAL;
        end else if (target == ALL_ID) begin
            dec.kind     = ACC_BCAST;
            dec.need_bus = write;
            dec.err      = !write;
        end else begin
            dec.kind     = ACC_REMOTE;
            dec.need_bus = 1'b1;
        end
    end

endmodule

// File: rtl/mp_prio_pick.sv
module mp_prio_pick
    import mp_arb_pkg::*;
#(
    parameter int NODES = 6,
    parameter int ID_W  = 3
) (
    input  logic [NODES-1:0] req,
    input  logic             rotate,
    input  logic [ID_W-1:0]  last_node,
    output logic             hit,
    output logic [ID_W-1:0]  win_id
);
    always_comb begin
        hit    = 1'b0;
        win_id = '0;
        for (int k = 0; k < NODES; k++) begin
            int cand;
            cand = rotate ? rr_candidate(int'(last_node), k, NODES) : k + 1;
            if (!hit && req[cand-1]) begin
                hit    = 1'b1;
                win_id = ID_W'(cand);
            end
        end
    end

endmodule

// File: rtl/mp_owner_fsm.sv
module mp_owner_fsm
    import mp_arb_pkg::*;
#(
    parameter int NODES = 6,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NODES-1:0] req_lines,
    input  logic             host_req,
    input  logic             lock_line,
    input  logic             xfer_busy,
    input  logic             win_hit,
    input  logic [ID_W-1:0]  win_id,
    output logic [ID_W-1:0]  owner_id,
    output logic             owner_valid,
    output logic [ID_W-1:0]  last_node
);
    localparam logic [ID_W-1:0] HOST_ID  = ID_W'(HOST_CODE);
    localparam logic [ID_W-1:0] FIRST_ID = ID_W'(1);

    logic [ID_W-1:0] owner_q, next_q, last_q;
    logic            turn_q;
    logic [NODES:0]  all_req;
    logic            owner_req, owner_is_host;
    logic            go;
    logic [ID_W-1:0] target;

    assign all_req       = {req_lines, host_req};
    assign owner_req     = all_req[owner_q];
    assign owner_is_host = (owner_q == HOST_ID);

    always_comb begin
        go     = 1'b0;
        target = owner_q;
        if (!turn_q && !lock_line) begin
            if (host_req && !owner_is_host) begin
                if (!xfer_busy) begin
                    go     = 1'b1;
                    target = HOST_ID;
                end
            end else if (!owner_req && win_hit && win_id != owner_q) begin
                go     = 1'b1;
                target = win_id;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= FIRST_ID;
            next_q  <= FIRST_ID;
            last_q  <= FIRST_ID;
            turn_q  <= 1'b0;
        end else if (turn_q) begin
            owner_q <= next_q;
            turn_q  <= 1'b0;
            if (next_q != HOST_ID) begin
                last_q <= next_q;
            end
        end else if (go) begin
            next_q <= target;
            turn_q <= 1'b1;
        end
    end

    assign owner_id    = owner_q;
    assign owner_valid = !turn_q;
    assign last_node   = last_q;

endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
    import mp_arb_pkg::*;
#(
    parameter int NODES     = 6,
    parameter int ID_W      = 3,
    parameter int ADDR_W    = 32,
    parameter int SLICE_LSB = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   my_id,
    input  logic              rotate_en,
    input  logic [NODES-1:0]  req_lines,
    input  logic              host_req,
    input  logic              lock_line,
    input  logic              xfer_busy,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        acc_kind,
    output logic              bus_req_out,
    output logic              bcast_err,
    output logic [ID_W-1:0]   owner_id,
    output logic              owner_valid,
    output logic              host_grant,
    output logic              is_master
);
    decode_t         dec;
    logic            win_hit;
    logic [ID_W-1:0] win_id;
    logic [ID_W-1:0] last_node;

    mp_addr_decode #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .SLICE_LSB(SLICE_LSB)
    ) u_decode (
        .addr(acc_addr), .write(acc_write), .my_id(my_id), .dec(dec)
    );

    mp_prio_pick #(
        .NODES(NODES), .ID_W(ID_W)
    ) u_pick (
        .req(req_lines), .rotate(rotate_en), .last_node(last_node),
        .hit(win_hit), .win_id(win_id)
    );

    mp_owner_fsm #(
        .NODES(NODES), .ID_W(ID_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_lines(req_lines), .host_req(host_req),
        .lock_line(lock_line), .xfer_busy(xfer_busy),
        .win_hit(win_hit), .win_id(win_id),
        .owner_id(owner_id), .owner_valid(owner_valid), .last_node(last_node)
    );

    assign acc_kind    = dec.kind;
    assign bus_req_out = acc_valid && dec.need_bus;
    assign bcast_err   = acc_valid && dec.err;
    assign host_grant  = owner_valid && (owner_id == ID_W'(HOST_CODE));
    assign is_master   = owner_valid && (owner_id == my_id);

endmodule

// File: rtl/mp_arb_chk.sv
module mp_arb_chk #(
    parameter int NODES = 6,
    parameter int ID_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       acc_kind,
    input logic             bus_req_out,
    input logic             bcast_err,
    input logic [ID_W-1:0]  owner_id,
    input logic             owner_valid,
    input logic             host_req,
    input logic             lock_line,
    input logic             xfer_busy,
    input logic [NODES-1:0] req_lines
);
    // R1
    local_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'd0 |-> !bus_req_out);

    // R4
    bcast_read_chk: assert property (@(posedge clk) disable iff (rst)
        bcast_err |-> (acc_kind == 2'd2) && !bus_req_out);

    // R8
    turn_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !owner_valid |=> owner_valid);

    // R8
    owner_steady_chk: assert property (@(posedge clk) disable iff (rst)
        owner_valid && $past(owner_valid) |-> owner_id == $past(owner_id));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        owner_valid && lock_line |=> owner_valid && $stable(owner_id));

    // R10
    host_take_chk: assert property (@(posedge clk) disable iff (rst)
        owner_valid && owner_id != '0 && host_req && !xfer_busy && !lock_line
        |=> !owner_valid);

    // R11
    owner_keep_chk: assert property (@(posedge clk) disable iff (rst)
        owner_valid && owner_id != '0 && req_lines[owner_id - 1'b1] && !host_req
        |=> owner_valid && $stable(owner_id));
endmodule

bind mp_bus_arbiter mp_arb_chk #(.NODES(NODES), .ID_W(ID_W)) u_arb_chk (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .bus_req_out(bus_req_out),
    .bcast_err(bcast_err), .owner_id(owner_id), .owner_valid(owner_valid),
    .host_req(host_req), .lock_line(lock_line), .xfer_busy(xfer_busy),
    .req_lines(req_lines)
);

// File: tb/test_mp_bus_arbiter.sv
module test_mp_bus_arbiter;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  my_id;
    logic        rotate_en, host_req, lock_line, xfer_busy;
    logic [5:0]  req_lines;
    logic        acc_valid, acc_write;
    logic [31:0] acc_addr;
    logic [1:0]  acc_kind;
    logic        bus_req_out, bcast_err, owner_valid, host_grant, is_master;
    logic [2:0]  owner_id;

    int checks = 0;
    int errors = 0;
    int exp_owner;

    always #4 clk = ~clk;

    mp_bus_arbiter i_mp_bus_arbiter (
        .clk(clk), .rst(rst), .my_id(my_id), .rotate_en(rotate_en),
        .req_lines(req_lines), .host_req(host_req), .lock_line(lock_line),
        .xfer_busy(xfer_busy), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .bus_req_out(bus_req_out),
        .bcast_err(bcast_err), .owner_id(owner_id), .owner_valid(owner_valid),
        .host_grant(host_grant), .is_master(is_master)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick(input int pat, input bit rot, input int last);
        for (int k = 0; k < 6; k++) begin
            int c;
            c = rot ? ((last + k) % 6) + 1 : k + 1;
            if (pat[c-1]) return c;
        end
        return 0;
    endfunction

    task automatic check_owner(input int exp, input string tag);
        chk(owner_valid == 1'b1, {tag, " valid"}, int'(owner_valid), 1);
        chk(int'(owner_id) == exp, {tag, " owner"}, int'(owner_id), exp);
        chk(is_master == (exp == int'(my_id)), "R12 is_master", int'(is_master),
            int'(exp == int'(my_id)));
        chk(host_grant == (exp == 0), "R10 host_grant", int'(host_grant), int'(exp == 0));
    endtask

    // Release the owner's request, offer pattern pat, and follow the handover.
    task automatic arb_step(input int pat, input string tag);
        int eff, win;
        eff = pat & ~(1 << (exp_owner - 1));
        win = pick(eff, rotate_en, exp_owner);
        @(negedge clk) req_lines = 6'(eff);
        @(negedge clk);
        if (win != 0) begin
            chk(owner_valid == 1'b0, "R8 turnaround", int'(owner_valid), 0);
            @(negedge clk);
            check_owner(win, tag);
            exp_owner = win;
        end else begin
            check_owner(exp_owner, "R11 park");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; my_id = 3'd3; rotate_en = 1'b0; host_req = 1'b0;
        lock_line = 1'b0; xfer_busy = 1'b0; req_lines = '0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R5 reset state
        check_owner(1, "R5 reset");

        // R1..R4 decode sweep over every ID and every 1 MiB slice
        acc_valid = 1'b1;
        for (int id = 1; id <= 6; id++) begin
            for (int s = 0; s < 20; s++) begin
                for (int w = 0; w < 2; w++) begin
                    int ek, er, ee;
                    my_id = 3'(id); acc_write = w[0];
                    acc_addr = (s < 16) ? 32'((s << 20) + 32'h5A5A5) : 32'hFFFF_FFF0 - 32'(s);
                    if (s >= 8)           begin ek = 3; er = 1; ee = 0; end
                    else if (s == 0 || s == id) begin ek = 0; er = 0; ee = 0; end
                    else if (s == 7)      begin ek = 2; er = w; ee = 1 - w; end
                    else                  begin ek = 1; er = 1; ee = 0; end
                    #1;
                    chk(int'(acc_kind) == ek, "R1/R2/R3/R4 kind", int'(acc_kind), ek);
                    chk(int'(bus_req_out) == er, "R1/R2/R3/R4 request", int'(bus_req_out), er);
                    chk(int'(bcast_err) == ee, "R4 error", int'(bcast_err), ee);
                end
            end
        end
        // boundary addresses
        my_id = 3'd2; acc_write = 1'b0;
        acc_addr = 32'h000F_FFFF; #1;
        chk(acc_kind == 2'd0 && !bus_req_out, "R1 top of internal", int'(acc_kind), 0);
        acc_addr = 32'h0080_0000; #1;
        chk(acc_kind == 2'd3 && bus_req_out, "R2 base of external", int'(acc_kind), 3);
        acc_addr = 32'h007F_FFFF; #1;
        chk(bcast_err && !bus_req_out, "R4 broadcast read top", int'(bcast_err), 1);
        acc_addr = 32'h0030_0000; acc_valid = 1'b0; #1;
        chk(!bus_req_out, "R3 no request without valid", int'(bus_req_out), 0);

        // R6 fixed and R7 rotating sweeps over all request patterns
        my_id = 3'd3;
        exp_owner = 1;
        for (int m = 0; m < 2; m++) begin
            @(negedge clk) rotate_en = m[0];
            for (int p = 1; p < 64; p++) begin
                arb_step(p, m == 0 ? "R6 fixed" : "R7 rotating");
            end
        end

        // R11 owner keeps the bus while requesting
        @(negedge clk) req_lines = 6'h3F;
        repeat (3) begin
            @(negedge clk);
            check_owner(exp_owner, "R11 hold");
        end

        // R9 lock: owner releases, others and host request, nothing moves
        @(negedge clk);
        lock_line = 1'b1; host_req = 1'b1;
        req_lines = 6'(6'h3F & ~(1 << (exp_owner - 1)));
        repeat (4) begin
            @(negedge clk);
            check_owner(exp_owner, "R9 lock");
        end

        // R10 host waits for busy, then takes over ahead of nodes
        lock_line = 1'b0; xfer_busy = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_owner(exp_owner, "R10 busy wait");
        end
        xfer_busy = 1'b0;
        @(negedge clk);
        chk(owner_valid == 1'b0, "R8 turnaround to host", int'(owner_valid), 0);
        @(negedge clk);
        check_owner(0, "R10 host");
        repeat (2) begin
            @(negedge clk);
            check_owner(0, "R10 host hold");
        end

        // host releases, fixed mode picks lowest requester
        rotate_en = 1'b0; host_req = 1'b0;
        begin
            int w;
            w = pick(int'(req_lines), 1'b0, 1);
            @(negedge clk);
            chk(owner_valid == 1'b0, "R8 turnaround from host", int'(owner_valid), 0);
            @(negedge clk);
            check_owner(w, "R6 after host");
            exp_owner = w;
        end

        // host parks when nobody requests
        @(negedge clk) host_req = 1'b1; req_lines = '0;
        @(negedge clk);
        @(negedge clk);
        check_owner(0, "R10 host again");
        host_req = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_owner(0, "R11 host park");
        end
        req_lines = 6'b100000;
        @(negedge clk);
        chk(owner_valid == 1'b0, "R8 turnaround to node 6", int'(owner_valid), 0);
        @(negedge clk);
        check_owner(6, "R6 single requester");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule